// File: doc/BRIEF.md
# Compare Flags and Conditional Branch Unit

This block holds the condition state of a small processor core. A compare operation takes two register values and loads a five-bit condition register that records equality together with separate signed and unsigned ordering results. A later conditional-branch instruction presents its 8-bit opcode, the address of the instruction and a 32-bit absolute destination. The block tests the latched condition bits for that opcode and returns whether the branch is taken and which address to fetch next.

Branch evaluation is combinational from the latched condition register. A compare and a branch offered in the same cycle therefore see the flags from before that compare. Compound conditions such as "greater or equal" are formed from the ordering bit OR the equality bit. A branch instruction is six bytes long: two opcode bytes followed by four destination bytes. When the branch is not taken, execution continues six bytes on. Opcodes outside the branch range are reported as illegal.

Top module: `cbu_branch_unit`

## Requirements
- R1: Condition bit positions are EQ=bit0, LT=bit1, GT=bit2, LTU=bit3, GTU=bit4. A compare sets EQ exactly when the two operands are equal.
- R2: A compare sets LT when operand A is less than operand B as two's-complement numbers, and GT when A is greater, clearing each otherwise.
- R3: A compare sets LTU when A is less than B as unsigned numbers, and GTU when A is greater, clearing each otherwise.
- R4: The condition register changes only on a cycle with cmp_en high. Branches, illegal opcodes and idle cycles leave it unchanged.
- R5: A clock edge with rst_n low clears all five condition bits.
- R6: Opcode 0x0F is taken when EQ is set, and opcode 0x10 is taken when EQ is clear.
- R7: Opcodes 0x11, 0x12, 0x13 and 0x14 are taken when LT, GT, LTU and GTU are set, respectively.
- R8: Opcode 0x15 is taken when GT or EQ is set, and opcode 0x16 is taken when LT or EQ is set.
- R9: Opcode 0x17 is taken when GTU or EQ is set, and opcode 0x18 is taken when LTU or EQ is set.
- R10: br_next_pc equals br_dest when br_taken is high. Otherwise it equals br_pc+6, wrapping at the address width.
- R11: With br_en high and an opcode outside 0x0F..0x18, br_illegal is 1 and br_taken is 0. With br_en low, both br_illegal and br_taken are 0.
- R12: Condition bits loaded by a compare become visible to branches one clock edge later. A branch in the same cycle as a compare uses the older flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmp_en | input | 1 | Load the condition register from this cycle's compare |
| cmp_a | input | DATA_W | Compare operand A |
| cmp_b | input | DATA_W | Compare operand B |
| br_en | input | 1 | A branch instruction is presented |
| br_op | input | 8 | Branch opcode |
| br_pc | input | ADDR_W | Address of the branch instruction |
| br_dest | input | ADDR_W | Absolute branch destination |
| cc_flags | output | 5 | Latched condition bits {GTU,LTU,GT,LT,EQ} |
| br_taken | output | 1 | Branch condition met |
| br_next_pc | output | ADDR_W | Next fetch address |
| br_illegal | output | 1 | Opcode outside the branch range |

## Verification
The bench builds the unit with DATA_W=4 and keeps ADDR_W at 32. The narrow operand width makes all 256 operand pairs reachable, including every sign-boundary case where the signed and unsigned orderings disagree. After each compare, the bench checks the latched flags and all ten branch opcodes. It also sweeps every opcode outside the branch range, runs next-address cases that wrap past the top of the 32-bit space, and checks a compare and a branch issued in the same cycle.

// File: rtl/cbu_pkg.sv
// Package: shared constants for the compare/branch unit.
// Assumes opcodes are 8 bits and the branch range is contiguous.
package cbu_pkg;
    localparam int FLAG_W = 5;
    localparam int FL_EQ  = 0;
    localparam int FL_LT  = 1;
    localparam int FL_GT  = 2;
    localparam int FL_LTU = 3;
    localparam int FL_GTU = 4;

    localparam int OP_W = 8;
    localparam logic [OP_W-1:0] OP_BEQ  = 8'h0F;
    localparam logic [OP_W-1:0] OP_BNE  = 8'h10;
    localparam logic [OP_W-1:0] OP_BLT  = 8'h11;
    localparam logic [OP_W-1:0] OP_BGT  = 8'h12;
    localparam logic [OP_W-1:0] OP_BLTU = 8'h13;
    localparam logic [OP_W-1:0] OP_BGTU = 8'h14;
    localparam logic [OP_W-1:0] OP_BGE  = 8'h15;
    localparam logic [OP_W-1:0] OP_BLE  = 8'h16;
    localparam logic [OP_W-1:0] OP_BGEU = 8'h17;
    localparam logic [OP_W-1:0] OP_BLEU = 8'h18;

    localparam int INSN_BYTES = 6;
endpackage

// File: rtl/cbu_flag_calc.sv
// Module: cbu_flag_calc
// Derives all five condition bits from a single shared subtractor.
// Assumes DATA_W >= 2. The logic is purely combinational.
module cbu_flag_calc
    import cbu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] lhs,
    input  logic [DATA_W-1:0] rhs,
    output logic [FLAG_W-1:0] flags_nxt
);
    localparam int MSB = DATA_W - 1;

    logic [DATA_W:0] diff;
    logic            borrow;
    logic            is_eq;
    logic            lt_s;

    // Subtract once; the borrow bit gives the unsigned ordering.
    always_comb begin
        diff   = {1'b0, lhs} - {1'b0, rhs};
        borrow = diff[DATA_W];
        is_eq  = (diff[MSB:0] == '0);
        // With differing signs, the negative operand is the smaller one.
        lt_s   = (lhs[MSB] ^ rhs[MSB]) ? lhs[MSB] : borrow;
    end

    // Pack the condition bits into their fixed positions.
    always_comb begin
        flags_nxt          = '0;
        flags_nxt[FL_EQ]   = is_eq;
        flags_nxt[FL_LTU]  = borrow;
        flags_nxt[FL_GTU]  = !borrow && !is_eq;
        flags_nxt[FL_LT]   = lt_s;
        flags_nxt[FL_GT]   = !lt_s && !is_eq;
    end
endmodule

// File: rtl/cbu_flag_reg.sv
// Module: cbu_flag_reg
// Condition register that loads only on a compare.
// Assumes a synchronous active-low reset.
module cbu_flag_reg
    import cbu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [FLAG_W-1:0] flags_d,
    output logic [FLAG_W-1:0] flags_q
);
    // Hold the flags, replacing them only when a compare is presented.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flags_q <= '0;
        else if (load)
            flags_q <= flags_d;
    end

    assert_reset_clear_R5: assert property (@(posedge clk)
        !rst_n |=> flags_q == '0);
    assert_hold_without_cmp_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(flags_q));
    assert_signed_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({flags_q[FL_EQ], flags_q[FL_LT], flags_q[FL_GT]}));
    assert_unsigned_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({flags_q[FL_EQ], flags_q[FL_LTU], flags_q[FL_GTU]}));
endmodule

// File: rtl/cbu_branch_sel.sv
// Module: cbu_branch_sel
// Decodes a branch opcode, tests the latched flags and forms the
// next address. Assumes a fixed six-byte branch instruction.
module cbu_branch_sel
    import cbu_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              valid,
    input  logic [OP_W-1:0]   opcode,
    input  logic [ADDR_W-1:0] pc,
    input  logic [ADDR_W-1:0] target,
    input  logic [FLAG_W-1:0] flags,
    output logic              taken,
    output logic              illegal,
    output logic [ADDR_W-1:0] next_pc
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INSN_BYTES);

    logic cond_hit;
    logic known;
    logic eq, lt, gt, ltu, gtu;

    // Select the condition that matches the opcode.
    always_comb begin
        eq  = flags[FL_EQ];
        lt  = flags[FL_LT];
        gt  = flags[FL_GT];
        ltu = flags[FL_LTU];
        gtu = flags[FL_GTU];
        known    = 1'b1;
        cond_hit = 1'b0;
        case (opcode)
            OP_BEQ:  cond_hit = eq;
            OP_BNE:  cond_hit = !eq;
            OP_BLT:  cond_hit = lt;
            OP_BGT:  cond_hit = gt;
            OP_BLTU: cond_hit = ltu;
            OP_BGTU: cond_hit = gtu;
            OP_BGE:  cond_hit = gt || eq;
            OP_BLE:  cond_hit = lt || eq;
            OP_BGEU: cond_hit = gtu || eq;
            OP_BLEU: cond_hit = ltu || eq;
            default: known    = 1'b0;
        endcase
    end

    // Qualify by valid and choose the destination or the fall-through address.
    always_comb begin
        taken   = valid && known && cond_hit;
        illegal = valid && !known;
        next_pc = taken ? target : pc + STEP;
    end
endmodule

// File: rtl/cbu_branch_unit.sv
// Module: cbu_branch_unit (top)
// Compare-flags register plus conditional-branch resolution.
// Assumes branches read the flags latched before the current edge.
module cbu_branch_unit
    import cbu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmp_en,
    input  logic [DATA_W-1:0] cmp_a,
    input  logic [DATA_W-1:0] cmp_b,
    input  logic              br_en,
    input  logic [7:0]        br_op,
    input  logic [ADDR_W-1:0] br_pc,
    input  logic [ADDR_W-1:0] br_dest,
    output logic [4:0]        cc_flags,
    output logic              br_taken,
    output logic [ADDR_W-1:0] br_next_pc,
    output logic              br_illegal
);
    logic [FLAG_W-1:0] flags_nxt;
    logic [FLAG_W-1:0] flags_q;

    cbu_flag_calc #(.DATA_W(DATA_W)) calc_i (
        .lhs       (cmp_a),
        .rhs       (cmp_b),
        .flags_nxt (flags_nxt)
    );

    cbu_flag_reg reg_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (cmp_en),
        .flags_d (flags_nxt),
        .flags_q (flags_q)
    );

    cbu_branch_sel #(.ADDR_W(ADDR_W)) sel_i (
        .valid   (br_en),
        .opcode  (br_op),
        .pc      (br_pc),
        .target  (br_dest),
        .flags   (flags_q),
        .taken   (br_taken),
        .illegal (br_illegal),
        .next_pc (br_next_pc)
    );

    assign cc_flags = flags_q;

    assert_taken_dest_R10: assert property (@(posedge clk) disable iff (!rst_n)
        br_taken |-> br_next_pc == br_dest);
    assert_illegal_not_taken_R11: assert property (@(posedge clk) disable iff (!rst_n)
        br_illegal |-> !br_taken);
    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !br_en |-> !br_taken && !br_illegal);
    assert_cmp_visible_R12: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_en |=> cc_flags == $past(flags_nxt));
endmodule

// File: tb/cbu_branch_unit_tb_top.sv
module cbu_branch_unit_tb_top;
    localparam int DW = 4;
    localparam int AW = 32;
    localparam time CLK_PERIOD = 10ns;
    localparam int WATCHDOG = 100000;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          cmp_en;
    logic [DW-1:0] cmp_a, cmp_b;
    logic          br_en;
    logic [7:0]    br_op;
    logic [AW-1:0] br_pc, br_dest;
    logic [4:0]    cc_flags;
    logic          br_taken;
    logic [AW-1:0] br_next_pc;
    logic          br_illegal;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    cbu_branch_unit #(.DATA_W(DW), .ADDR_W(AW)) dut_i (
        .clk, .rst_n, .cmp_en, .cmp_a, .cmp_b, .br_en, .br_op, .br_pc, .br_dest,
        .cc_flags, .br_taken, .br_next_pc, .br_illegal
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Expected flags {GTU,LTU,GT,LT,EQ}, computed arithmetically.
    function automatic logic [4:0] exp_flags(input int a, input int b);
        int sa = (a >= (1 << (DW-1))) ? a - (1 << DW) : a;
        int sb = (b >= (1 << (DW-1))) ? b - (1 << DW) : b;
        return {a > b, a < b, sa > sb, sa < sb, a == b};
    endfunction

    function automatic bit exp_take(input int op, input logic [4:0] f);
        case (op)
            8'h0F: return f[0];
            8'h10: return !f[0];
            8'h11: return f[1];
            8'h12: return f[2];
            8'h13: return f[3];
            8'h14: return f[4];
            8'h15: return f[2] | f[0];
            8'h16: return f[1] | f[0];
            8'h17: return f[4] | f[0];
            8'h18: return f[3] | f[0];
            default: return 1'b0;
        endcase
    endfunction

    function automatic string req_of(input int op);
        if (op <= 8'h10) return "R6";
        if (op <= 8'h14) return "R7";
        if (op <= 8'h16) return "R8";
        return "R9";
    endfunction

    task automatic do_cmp(input int a, input int b);
        @(negedge clk);
        cmp_a = DW'(a); cmp_b = DW'(b); cmp_en = 1'b1; br_en = 1'b0;
        @(negedge clk);
        cmp_en = 1'b0;
        #1;
    endtask

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        logic [4:0] ef;
        logic [AW-1:0] pcv;
        rst_n = 1'b0; cmp_en = 1'b0; cmp_a = '0; cmp_b = '0;
        br_en = 1'b0; br_op = '0; br_pc = '0; br_dest = '0;
        repeat (2) @(negedge clk);
        #1;
        check("R5 reset flags", 64'(cc_flags), 64'h0);
        rst_n = 1'b1;

        // Exhaustive operand sweep, each followed by all ten branches.
        for (int a = 0; a < (1 << DW); a++) begin
            for (int b = 0; b < (1 << DW); b++) begin
                do_cmp(a, b);
                ef = exp_flags(a, b);
                check("R1 R2 R3 flags", 64'(cc_flags), 64'(ef));
                for (int op = 8'h0F; op <= 8'h18; op++) begin
                    pcv = 32'hFFFF_FFF0 + AW'(a * 16 + b);
                    br_en = 1'b1; br_op = 8'(op); br_pc = pcv;
                    br_dest = 32'h1000_0000 + AW'(op);
                    #1;
                    check({req_of(op), " taken"}, 64'(br_taken), 64'(exp_take(op, ef)));
                    check("R10 next pc", 64'(br_next_pc),
                          exp_take(op, ef) ? 64'(br_dest) : 64'(AW'(pcv + 6)));
                end
                @(negedge clk);
                br_en = 1'b0;
                #1;
                check("R4 flags held after branches", 64'(cc_flags), 64'(ef));
            end
        end

        // Illegal opcodes: flagged, never taken, flags untouched.
        do_cmp(3, 3);
        for (int op = 0; op < 256; op++) begin
            if (op >= 8'h0F && op <= 8'h18) continue;
            br_en = 1'b1; br_op = 8'(op); br_pc = 32'hFFFF_FFFE; br_dest = 32'h40;
            #1;
            check("R11 illegal", 64'(br_illegal), 64'h1);
            check("R11 not taken", 64'(br_taken), 64'h0);
            check("R10 wrap", 64'(br_next_pc), 64'h4);
        end
        @(negedge clk);
        #1;
        check("R4 illegal leaves flags", 64'(cc_flags), 64'(exp_flags(3, 3)));

        // Idle branch port: no take, no illegal.
        br_en = 1'b0; br_op = 8'h0F;
        #1;
        check("R11 idle taken", 64'(br_taken), 64'h0);
        check("R11 idle illegal", 64'(br_illegal), 64'h0);

        // Same-cycle compare and branch use the older flags.
        do_cmp(1, 2);
        @(negedge clk);
        cmp_en = 1'b1; cmp_a = 4'd2; cmp_b = 4'd2;
        br_en = 1'b1; br_op = 8'h0F; br_pc = 32'h100; br_dest = 32'h200;
        #1;
        check("R12 old flags used", 64'(br_taken), 64'h0);
        @(negedge clk);
        cmp_en = 1'b0;
        #1;
        check("R12 new flags visible", 64'(br_taken), 64'h1);
        check("R12 next pc", 64'(br_next_pc), 64'h200);

        // Reset mid-run clears flags.
        br_en = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        #1;
        check("R5 reset after use", 64'(cc_flags), 64'h0);
        rst_n = 1'b1;

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule